// File: doc/BRIEF.md
# Bus-Request DMA Transfer Controller

A single-channel engine that copies words from one memory region to another without the host processor touching each word. Software loads a source pointer, a destination pointer, a word count and a pacing mode through a small register port, then writes the control register to launch. The engine asks the host for the shared memory bus with a request/grant handshake. It moves each word as a read followed by a write and returns the bus when the copy is over. It then raises a sticky completion flag that drives an interrupt line.

Three pacing policies decide how the bus is shared. Burst holds the bus from first word to last. Cycle-steal drops the request after every word, so the host wins the bus back in between. Transparent moves a word only in cycles where the host reports that its bus is idle. A gather mode walks a small on-chip table of (source pointer, length, flags) entries in index order. It packs the pieces one after another into a single destination run.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: Register offsets (5-bit address, bit 4 clear) are: 0 source pointer, 1 destination pointer, 2 word count, 3 pacing mode (bits 1:0: 0 burst, 1 cycle-steal, 2 transparent, 3 behaves as burst), 4 control, 5 status. Values written while idle read back at the same offset.
- R2: Once launched, the engine raises `bus_req_o` and moves no word (`mem_rd_o`/`mem_we_o` stay low) until `bus_gnt_i` is high. Every read or write cycle happens while both are high.
- R3: In burst mode the request stays high from the first word of a run to its last word, so it rises exactly once per plain transfer.
- R4: In cycle-steal mode the request drops for at least one cycle after each word's write, so a plain transfer of N words raises the request N times.
- R5: In transparent mode no read or write cycle happens in a cycle where `bus_idle_i` is low.
- R6: After the last word's write, the request is low, status bit 0 (complete) is set and `irq_o` is high. Status bit 2 reads 1 while a transfer is active and 0 otherwise.
- R7: Writing status with bit 0 set clears the complete flag and drops `irq_o`. Writing it with bit 1 set clears the error flag. This write is accepted while a transfer is active.
- R8: Launching a plain transfer with count 0, or reaching a table entry of length 0, sets status bit 1 (error) and ends without raising the request for that entry. The complete flag is not set.
- R9: Word k of a plain transfer copies memory at source+k to destination+k. The source, destination and count registers read the live pointers and remaining count, ending at source+N, destination+N and 0.
- R10: While a transfer is active, writes to the pointer, count, mode, control and table registers are ignored.
- R11: Writing control with bit 0 (start) and bit 1 (gather) set processes table entries from index 0 upward. Each entry copies `length` words from its own source pointer, and the destination continues from the previous entry. Table address is 16 + 4*index + field, with field 0 source pointer, 1 length, 2 flags.
- R12: In gather mode the engine stops after an entry whose flags bit 0 (last) is set, or after the final table slot, whichever comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | $clog2(SG_N)+3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| bus_req_o | output | 1 | Request for the shared memory bus |
| bus_gnt_i | input | 1 | Bus granted by the host |
| bus_idle_i | input | 1 | Host is not using the bus this cycle |
| mem_addr_o | output | AW | Memory word address |
| mem_rd_o | output | 1 | Read cycle; data returned on `mem_rdata_i` in the same cycle |
| mem_we_o | output | 1 | Write cycle |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its defaults: 16-bit pointers, 32-bit words, 12-bit count and a four-slot gather table. With four slots, a table without any last flag reaches the final-slot stop in a short run, and a sentinel word after the packed destination shows that nothing past the stop was written. A host model can hold the grant back indefinitely. That keeps a transfer active long enough to probe the live count and the ignored writes. A randomised idle signal exercises the transparent stalls.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    PACE_BURST  = 2'd0,
    PACE_STEAL  = 2'd1,
    PACE_TRANSP = 2'd2
  } pace_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_REQ, ST_RD, ST_WR, ST_GAP
  } xfer_st_e;

  localparam int OFF_SRC  = 0;
  localparam int OFF_DST  = 1;
  localparam int OFF_CNT  = 2;
  localparam int OFF_MODE = 3;
  localparam int OFF_CTRL = 4;
  localparam int OFF_STAT = 5;
endpackage

// File: rtl/dma_word_ctr.sv
module dma_word_ctr #(
  parameter int W    = 16,
  parameter bit DOWN = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         step_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] nxt;

  generate
    if (DOWN) begin : g_down
      assign nxt = val_o - W'(1);
    end else begin : g_up
      assign nxt = val_o + W'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_o <= '0;
    else if (ld_i)   val_o <= ld_val_i;
    else if (step_i) val_o <= nxt;
  end
endmodule

// File: rtl/dma_sg_table.sv
module dma_sg_table #(
  parameter int AW = 16,
  parameter int CW = 12,
  parameter int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [1:0]    field_i,
  input  logic [31:0]   wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] len_o,
  output logic          last_o
);
  logic [AW-1:0] ent_addr [N];
  logic [CW-1:0] ent_len  [N];
  logic          ent_last [N];

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic sel;
    assign sel = we_i && (widx_i == IW'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_addr[e] <= '0;
        ent_len[e]  <= '0;
        ent_last[e] <= 1'b0;
      end else if (sel) begin
        case (field_i)
          2'd0:    ent_addr[e] <= wdata_i[AW-1:0];
          2'd1:    ent_len[e]  <= wdata_i[CW-1:0];
          2'd2:    ent_last[e] <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  assign addr_o = ent_addr[ridx_i];
  assign len_o  = ent_len[ridx_i];
  assign last_o = ent_last[ridx_i];
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int CW   = 12,
  parameter int SG_N = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [$clog2(SG_N)+2:0]  reg_addr_i,
  input  logic [31:0]              reg_wdata_i,
  output logic [31:0]              reg_rdata_o,
  output logic                     bus_req_o,
  input  logic                     bus_gnt_i,
  input  logic                     bus_idle_i,
  output logic [AW-1:0]            mem_addr_o,
  output logic                     mem_rd_o,
  output logic                     mem_we_o,
  output logic [DW-1:0]            mem_wdata_o,
  input  logic [DW-1:0]            mem_rdata_i,
  output logic                     irq_o
);
  localparam int IW  = $clog2(SG_N);
  localparam int RAW = IW + 3;

  xfer_st_e      st_q;
  pace_e         pace;
  logic [1:0]    mode_q;
  logic [IW-1:0] idx_q;
  logic          sg_q, ent_last_q, done_q, err_q;
  logic [DW-1:0] data_q;
  logic [AW-1:0] src_q, dst_q, sg_addr;
  logic [CW-1:0] cnt_q, sg_len;
  logic          sg_last;
  logic          busy, go, rd_fire, wr_fire, last_word, run_end;
  logic          start, stat_wr, ld_entry;

  function automatic logic cfg_wr(input int off);
    return reg_we_i && !busy && (reg_addr_i == RAW'(off));
  endfunction

  assign busy     = (st_q != ST_IDLE);
  assign start    = cfg_wr(OFF_CTRL) && reg_wdata_i[0];
  assign stat_wr  = reg_we_i && (reg_addr_i == RAW'(OFF_STAT));
  assign ld_entry = (st_q == ST_LOAD);

  always_comb begin
    case (mode_q)
      2'd1:    pace = PACE_STEAL;
      2'd2:    pace = PACE_TRANSP;
      default: pace = PACE_BURST;
    endcase
  end

  // transparent pacing waits for host idle on every data cycle
  assign go        = bus_gnt_i && ((pace != PACE_TRANSP) || bus_idle_i);
  assign rd_fire   = (st_q == ST_RD) && go;
  assign wr_fire   = (st_q == ST_WR) && go;
  assign last_word = (cnt_q == CW'(1));
  assign run_end   = wr_fire && last_word && !(sg_q && !ent_last_q);

  dma_sg_table #(.AW(AW), .CW(CW), .N(SG_N)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i && !busy && reg_addr_i[RAW-1]),
    .widx_i  (reg_addr_i[RAW-2:2]),
    .field_i (reg_addr_i[1:0]),
    .wdata_i (reg_wdata_i),
    .ridx_i  (idx_q),
    .addr_o  (sg_addr),
    .len_o   (sg_len),
    .last_o  (sg_last)
  );

  dma_word_ctr #(.W(AW), .DOWN(1'b0)) u_src (
    .clk_i, .rst_ni,
    .ld_i     (cfg_wr(OFF_SRC) || ld_entry),
    .ld_val_i (ld_entry ? sg_addr : reg_wdata_i[AW-1:0]),
    .step_i   (wr_fire),
    .val_o    (src_q)
  );

  dma_word_ctr #(.W(AW), .DOWN(1'b0)) u_dst (
    .clk_i, .rst_ni,
    .ld_i     (cfg_wr(OFF_DST)),
    .ld_val_i (reg_wdata_i[AW-1:0]),
    .step_i   (wr_fire),
    .val_o    (dst_q)
  );

  dma_word_ctr #(.W(CW), .DOWN(1'b1)) u_cnt (
    .clk_i, .rst_ni,
    .ld_i     (cfg_wr(OFF_CNT) || ld_entry),
    .ld_val_i (ld_entry ? sg_len : reg_wdata_i[CW-1:0]),
    .step_i   (wr_fire),
    .val_o    (cnt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      mode_q     <= '0;
      idx_q      <= '0;
      sg_q       <= 1'b0;
      ent_last_q <= 1'b0;
      data_q     <= '0;
    end else begin
      if (cfg_wr(OFF_MODE)) mode_q <= reg_wdata_i[1:0];
      if (rd_fire) data_q <= mem_rdata_i;
      unique case (st_q)
        ST_IDLE: if (start) begin
          sg_q  <= reg_wdata_i[1];
          idx_q <= '0;
          if (reg_wdata_i[1])          st_q <= ST_LOAD;
          else if (cnt_q != '0)        st_q <= ST_REQ;
        end
        ST_LOAD: begin
          ent_last_q <= sg_last || (idx_q == IW'(SG_N - 1));
          st_q       <= (sg_len == '0) ? ST_IDLE : ST_REQ;
        end
        ST_REQ: if (bus_gnt_i) st_q <= ST_RD;
        ST_RD:  if (rd_fire)   st_q <= ST_WR;
        ST_WR: if (wr_fire) begin
          if (last_word) begin
            if (sg_q && !ent_last_q) begin
              idx_q <= idx_q + IW'(1);
              st_q  <= ST_LOAD;
            end else begin
              st_q  <= ST_IDLE;
            end
          end else if (pace == PACE_STEAL) begin
            st_q <= ST_GAP;
          end else begin
            st_q <= ST_RD;
          end
        end
        ST_GAP:  st_q <= ST_REQ;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (run_end)                         done_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[0])  done_q <= 1'b0;
      if ((start && !reg_wdata_i[1] && cnt_q == '0) || (ld_entry && sg_len == '0))
        err_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[1])
        err_q <= 1'b0;
    end
  end

  assign bus_req_o   = (st_q == ST_REQ) || (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_rd_o    = rd_fire;
  assign mem_we_o    = wr_fire;
  assign mem_addr_o  = (st_q == ST_WR) ? dst_q : src_q;
  assign mem_wdata_o = data_q;
  assign irq_o       = done_q;

  always_comb begin
    case (reg_addr_i)
      RAW'(OFF_SRC):  reg_rdata_o = 32'(src_q);
      RAW'(OFF_DST):  reg_rdata_o = 32'(dst_q);
      RAW'(OFF_CNT):  reg_rdata_o = 32'(cnt_q);
      RAW'(OFF_MODE): reg_rdata_o = 32'(mode_q);
      RAW'(OFF_STAT): reg_rdata_o = {29'd0, busy, err_q, done_q};
      default:        reg_rdata_o = '0;
    endcase
  end

  AST_MOVE_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_we_o) |-> (bus_req_o && bus_gnt_i)); // R2
  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pace == PACE_BURST && mem_we_o && cnt_q != CW'(1)) |=> bus_req_o); // R3
  AST_STEAL_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pace == PACE_STEAL && mem_we_o) |=> !bus_req_o); // R4
  AST_TRANSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pace == PACE_TRANSP && (mem_rd_o || mem_we_o)) |-> bus_idle_i); // R5
  AST_DONE_FREES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !bus_req_o); // R6
  AST_ERR_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> (!bus_req_o && !mem_we_o)); // R8
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (cnt_q == $past(cnt_q) - CW'(1))); // R9
  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(mode_q)); // R10
endmodule

// File: tb/dma_xfer_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_ctrl_tb_top;
  localparam int AW = 16, DW = 32, CW = 12, SG_N = 4;
  localparam int RAW = $clog2(SG_N) + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [RAW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic bus_req, bus_gnt, bus_idle;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_we, irq;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic host_block = 1'b0, idle_rand = 1'b0, fill = 1'b0, mon_clr = 1'b0;
  int checks = 0, errors = 0, rises = 0, viol = 0;
  logic req_d;
  bit finished = 1'b0;
  logic [31:0] mem [0:255];

  always #2 clk = ~clk;

  dma_xfer_ctrl #(.AW(AW), .DW(DW), .CW(CW), .SG_N(SG_N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .bus_req_o(bus_req),
    .bus_gnt_i(bus_gnt), .bus_idle_i(bus_idle), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .irq_o(irq));

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h9E37_79B1) + 32'h0000_1234;
  endfunction

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < 256; i++) mem[i] <= (i < 128) ? pat(i) : 32'hDEAD_0000;
    end else if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req && !host_block;

  always @(posedge clk) bus_idle <= idle_rand ? 1'($urandom_range(0, 1)) : 1'b1;

  always @(posedge clk) begin
    if (mon_clr) begin
      rises <= 0; viol <= 0; req_d <= 1'b0;
    end else begin
      req_d <= bus_req;
      if (bus_req && !req_d) rises <= rises + 1;
      if ((mem_rd || mem_we) && !bus_idle) viol <= viol + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = RAW'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = RAW'(a); #0.5 d = reg_rdata;
  endtask

  task automatic prep();
    @(negedge clk); fill = 1'b1; mon_clr = 1'b1;
    @(negedge clk); fill = 1'b0; mon_clr = 1'b0;
    wr(5, 32'h3);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(5, s);
      if (!s[2]) return;
    end
    check("idle timeout", 32'd1, 32'd0);
  endtask

  function automatic int cmp_run(input int src, input int dst, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (mem[dst + i] !== pat(src + i)) bad++;
    return bad;
  endfunction

  task automatic plain(input int src, input int dst, input int n, input int mode);
    wr(0, 32'(src)); wr(1, 32'(dst)); wr(2, 32'(n)); wr(3, 32'(mode));
    wr(4, 32'h1);
    wait_idle();
    @(negedge clk);
  endtask

  task automatic sg_ent(input int idx, input int a, input int len, input int last);
    wr(16 + idx * 4 + 0, 32'(a));
    wr(16 + idx * 4 + 1, 32'(len));
    wr(16 + idx * 4 + 2, 32'(last));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(5, v); check("reset status", v, 32'h0);
    check("reset irq", 32'(irq), 32'h0);
    check("reset req", 32'(bus_req), 32'h0);

    // R1 readback
    prep();
    wr(0, 32'h11); wr(1, 32'h92); wr(2, 32'h7); wr(3, 32'h2);
    rd(0, v); check("R1 src", v, 32'h11);
    rd(1, v); check("R1 dst", v, 32'h92);
    rd(2, v); check("R1 cnt", v, 32'h7);
    rd(3, v); check("R1 mode", v, 32'h2);

    // R3 burst, R6 completion, R9 copy
    prep();
    plain(3, 140, 5, 0);
    check("R9 burst data", 32'(cmp_run(3, 140, 5)), 0);
    check("R3 burst req rises", 32'(rises), 1);
    rd(5, v); check("R6 status done", v, 32'h1);
    check("R6 irq", 32'(irq), 1);
    check("R6 req low", 32'(bus_req), 0);
    wr(5, 32'h1);
    check("R7 irq cleared", 32'(irq), 0);
    rd(5, v); check("R7 status cleared", v, 32'h0);

    // R4 cycle steal
    prep();
    plain(20, 150, 4, 1);
    check("R4 steal data", 32'(cmp_run(20, 150, 4)), 0);
    check("R4 steal req rises", 32'(rises), 4);

    // R5 transparent
    prep();
    idle_rand = 1'b1;
    plain(30, 160, 6, 2);
    idle_rand = 1'b0;
    check("R5 transparent data", 32'(cmp_run(30, 160, 6)), 0);
    check("R5 moves while host busy", 32'(viol), 0);

    // R8 zero count
    prep();
    plain(4, 170, 0, 0);
    rd(5, v); check("R8 zero count err", v, 32'h2);
    check("R8 no bus request", 32'(rises), 0);
    check("R8 dst untouched", mem[170], 32'hDEAD_0000);

    // R10 ignored writes, R9 live count, R7 status write while busy
    @(negedge clk); fill = 1'b1; mon_clr = 1'b1;
    @(negedge clk); fill = 1'b0; mon_clr = 1'b0;
    host_block = 1'b1;
    wr(0, 32'd10); wr(1, 32'd140); wr(2, 32'd6); wr(3, 32'd0); wr(4, 32'h1);
    repeat (3) @(negedge clk);
    rd(2, v); check("R9 live count", v, 32'd6);
    wr(0, 32'd50); wr(2, 32'd1); wr(3, 32'd1);
    wr(16, 32'd99);
    rd(0, v); check("R10 src write ignored", v, 32'd10);
    rd(2, v); check("R10 cnt write ignored", v, 32'd6);
    rd(3, v); check("R10 mode write ignored", v, 32'd0);
    wr(5, 32'h2);
    rd(5, v); check("R7 err clear while busy", v, 32'h4);
    host_block = 1'b0;
    wait_idle();
    @(negedge clk);
    check("R10 data", 32'(cmp_run(10, 140, 6)), 0);
    check("R10 burst kept", 32'(rises), 1);
    rd(0, v); check("R9 src end", v, 32'd16);
    rd(1, v); check("R9 dst end", v, 32'd146);
    rd(2, v); check("R9 cnt end", v, 32'd0);

    // R11 gather, R12 last flag
    prep();
    sg_ent(0, 5, 3, 0); sg_ent(1, 40, 2, 1); sg_ent(2, 70, 4, 0); sg_ent(3, 90, 1, 0);
    wr(1, 32'd150); wr(3, 32'd0); wr(4, 32'h3);
    wait_idle(); @(negedge clk);
    check("R11 entry0 data", 32'(cmp_run(5, 150, 3)), 0);
    check("R11 entry1 data", 32'(cmp_run(40, 153, 2)), 0);
    check("R12 stop at last flag", mem[155], 32'hDEAD_0000);
    rd(5, v); check("R11 gather done", v, 32'h1);

    // R12 final slot
    prep();
    sg_ent(0, 0, 1, 0); sg_ent(1, 20, 2, 0); sg_ent(2, 30, 1, 0); sg_ent(3, 60, 2, 0);
    wr(1, 32'd130); wr(3, 32'd1); wr(4, 32'h3);
    wait_idle(); @(negedge clk);
    check("R12 four entries data",
          32'(cmp_run(0, 130, 1) + cmp_run(20, 131, 2) + cmp_run(30, 133, 1) + cmp_run(60, 134, 2)), 0);
    check("R12 nothing after final slot", mem[136], 32'hDEAD_0000);
    rd(1, v); check("R12 dst end", v, 32'd136);

    // R8 zero-length entry
    prep();
    sg_ent(0, 8, 2, 0); sg_ent(1, 50, 0, 0);
    wr(1, 32'd180); wr(4, 32'h3);
    wait_idle(); @(negedge clk);
    check("R8 entry0 moved", 32'(cmp_run(8, 180, 2)), 0);
    rd(5, v); check("R8 zero length err", v, 32'h2);
    check("R8 nothing after", mem[182], 32'hDEAD_0000);

    // random plain transfers
    for (int t = 0; t < 20; t++) begin
      int s, d, n, m;
      s = $urandom_range(0, 100); d = $urandom_range(128, 200);
      n = $urandom_range(1, 8);   m = $urandom_range(0, 2);
      prep();
      idle_rand = (m == 2);
      plain(s, d, n, m);
      idle_rand = 1'b0;
      check($sformatf("R9 random copy t%0d", t), 32'(cmp_run(s, d, n)), 0);
      check($sformatf("R2 random done t%0d", t), 32'(irq), 1);
      if (m == 1) check($sformatf("R4 random rises t%0d", t), 32'(rises), 32'(n));
      else        check($sformatf("R3 R5 random rises t%0d", t), 32'(rises), 1);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule